// File: doc/BRIEF.md
# Cartridge Bank Mapping Register Decoder

This block listens to CPU writes in the upper half of a 6502-style address space and keeps the registers that place program and character memory. The program side has four 8 KB windows from 0x8000 to 0xFFFF. Two windows take their bank from writable registers. The other two are fixed to the last two banks of the 5-bit bank range. One mode bit decides whether the first switchable register sits at 0x8000 or at 0xC000. The 8 KB character space is split into eight 1 KB slices, and each slice has its own bank register. The block also holds a two-bit mirroring code for the video side.

All mapping outputs are combinational. For the CPU address on `cpu_addr`, the block gives the physical 8 KB program bank, with an outer bank bit placed above the 5-bit bank number. It also flags whether that address falls in the program ROM space or in the 8 KB work-RAM window at 0x6000. For the character address on `chr_addr`, it gives the 1 KB bank. Before a write is decoded, the low CPU address bits are folded together, so several address aliases reach the same register. The parameter `PAIR_MODE` selects a board variant. In that variant one write to the 0xA000 group loads both switchable program registers as an even/odd pair, and writes to the 0x8000 group do nothing.

There is no control state machine. The write path is a decoder that classifies each write into one of six targets (`TGT_NONE`, `TGT_PRG0`, `TGT_PRG1`, `TGT_MIRROR`, `TGT_MODE`, `TGT_CHR`). A target only moves register state on the clock edge of a write, and it never makes a sequence of states.

Top module: `bank_map_decoder`

## Requirements
- R1: Before a write is decoded, address bits [1:0] become addr[1:0] | addr[3:2] | addr[5:4] | addr[7:6]. Bits [15:12] are kept as they are, and bits [11:2] take no part in the decode. For example, 0x9008 decodes as 0x9002, 0x9010 as 0x9001, and 0xB040 as 0xB001.
- R2: In the default variant, a write whose decoded address is 0x8000–0x8003 loads program register 0 with data[4:0].
- R3: In the default variant, a write to 0xA000–0xA003 loads program register 1 with data[4:0]. With `PAIR_MODE`=1, the same write loads register 0 with {data[3:0],0} and register 1 with {data[3:0],1`}. In that variant, writes to 0x8000–0x8003 change nothing.
- R4: A write to 0x9000 or 0x9001 sets `mirror_mode` to data[1:0]. The exception is data equal to 0xFF: that write is ignored and the code is kept.
- R5: `mirror_mode` encodes 0 = vertical, 1 = horizontal, 2 = single page A and 3 = single page B.
- R6: A write to 0x9002 or 0x9003 stores data[1] as the swap bit. With swap clear, 0x8000–0x9FFF shows register 0 and 0xC000–0xDFFF shows bank 0x1E. With swap set, these two windows are exchanged.
- R7: 0xA000–0xBFFF always shows register 1, and 0xE000–0xFFFF always shows bank 0x1F. `prg_bank` is {OUTER_BIT, 5-bit bank}, with OUTER_BIT = 1 by default, so its value is 0x20 plus the bank.
- R8: A write whose decoded address has page P in 0xB–0xE selects character register {P−0xB, addr[1]}.
- R9: If the decoded addr[0] is 0, data[3:0] replaces the low nibble of the selected character register. If it is 1, data[3:0] replaces the high nibble. The other nibble is kept.
- R10: `chr_bank` equals the character register numbered chr_addr[12:10].
- R11: `wram_hit` is 1 exactly for 0x6000–0x7FFF and `prg_hit` is 1 exactly for 0x8000–0xFFFF. `prg_bank` is 0 whenever `prg_hit` is 0.
- R12: Reset clears every program register, character register, the swap bit and the mirroring code. Writes whose decoded page is outside 0x8–0xE change no output.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cpu_wr | input | 1 | Write strobe, one cycle per write |
| cpu_addr | input | 16 | CPU address, used for both write decode and program mapping |
| cpu_wdata | input | 8 | CPU write data |
| chr_addr | input | 13 | Character-space address |
| prg_bank | output | 6 | Physical 8 KB program bank for cpu_addr |
| prg_hit | output | 1 | cpu_addr lies in 0x8000–0xFFFF |
| wram_hit | output | 1 | cpu_addr lies in 0x6000–0x7FFF |
| chr_bank | output | 8 | Physical 1 KB character bank for chr_addr |
| mirror_mode | output | 2 | Nametable mirroring code |

## Verification
The assertions assume three things about the inputs. `cpu_wr` is a single-cycle strobe. `cpu_addr` and `cpu_wdata` hold known values across the edge that takes a write. Nothing besides a write may change register state. The bench drives every input on the falling edge and drops `cpu_wr` again one cycle later, so each write is seen on exactly one rising edge. It reads the combinational map only while `cpu_wr` is low. The pair variant is a second instance that shares the same inputs. Its expected values therefore take into account every write made earlier in the run.

// File: rtl/bank_map_pkg.sv
package bank_map_pkg;

    // Register targeted by a decoded CPU write
    typedef enum logic [2:0] {
        TGT_NONE,
        TGT_PRG0,
        TGT_PRG1,
        TGT_MIRROR,
        TGT_MODE,
        TGT_CHR
    } wr_tgt_e;

    // 8 KB program window selected by cpu_addr[14:13]
    typedef enum logic [1:0] {
        WIN_LO  = 2'd0,
        WIN_MID = 2'd1,
        WIN_HI  = 2'd2,
        WIN_TOP = 2'd3
    } prg_win_e;

    localparam logic [3:0] PAGE_PRG0   = 4'h8;
    localparam logic [3:0] PAGE_CTRL   = 4'h9;
    localparam logic [3:0] PAGE_PRG1   = 4'hA;
    localparam logic [3:0] PAGE_CHR_LO = 4'hB;

endpackage

// File: rtl/bank_wr_decode.sv
module bank_wr_decode
    import bank_map_pkg::*;
#(
    parameter int CHR_IDX_W = 3
) (
    input  logic [3:0]           addr_page,
    input  logic [7:0]           addr_low,
    output wr_tgt_e              tgt,
    output logic [CHR_IDX_W-1:0] chr_idx,
    output logic                 chr_hi
);
    logic [1:0] folded;
    logic [3:0] chr_off;

    always_comb begin
        // Alias folding of the low address byte into the register select bits
        folded  = addr_low[1:0] | addr_low[3:2] | addr_low[5:4] | addr_low[7:6];
        chr_off = addr_page - PAGE_CHR_LO;
        chr_idx = {chr_off[CHR_IDX_W-2:0], folded[1]};
        chr_hi  = folded[0];
        unique case (addr_page)
            PAGE_PRG0:                tgt = TGT_PRG0;
            PAGE_CTRL:                tgt = folded[1] ? TGT_MODE : TGT_MIRROR;
            PAGE_PRG1:                tgt = TGT_PRG1;
            4'hB, 4'hC, 4'hD, 4'hE:   tgt = TGT_CHR;
            default:                  tgt = TGT_NONE;
        endcase
    end

endmodule

// File: rtl/bank_regs.sv
module bank_regs
    import bank_map_pkg::*;
#(
    parameter int PRG_W     = 5,
    parameter int CHR_W     = 8,
    parameter int CHR_N     = 8,
    parameter bit PAIR_MODE = 1'b0,
    localparam int CHR_IDX_W = $clog2(CHR_N),
    localparam int NIB       = CHR_W / 2
) (
    input  logic                        clk,
    input  logic                        rst_n,
    input  logic                        wr_en,
    input  wr_tgt_e                     tgt,
    input  logic [CHR_IDX_W-1:0]        chr_idx,
    input  logic                        chr_hi,
    input  logic [7:0]                  wr_data,
    output logic [PRG_W-1:0]            prg0_q,
    output logic [PRG_W-1:0]            prg1_q,
    output logic [1:0]                  mirror_q,
    output logic                        swap_q,
    output logic [CHR_N-1:0][CHR_W-1:0] chr_q
);
    logic             ld_prg0, ld_prg1;
    logic [PRG_W-1:0] prg0_d, prg1_d;

    generate
        if (PAIR_MODE) begin : g_pair
            // One write loads an even/odd pair; the 0x8000 group is dead
            always_comb begin
                ld_prg0 = wr_en && (tgt == TGT_PRG1);
                ld_prg1 = ld_prg0;
                prg0_d  = {wr_data[PRG_W-2:0], 1'b0};
                prg1_d  = {wr_data[PRG_W-2:0], 1'b1};
            end
        end else begin : g_split
            always_comb begin
                ld_prg0 = wr_en && (tgt == TGT_PRG0);
                ld_prg1 = wr_en && (tgt == TGT_PRG1);
                prg0_d  = wr_data[PRG_W-1:0];
                prg1_d  = wr_data[PRG_W-1:0];
            end

            AST_PRG0_LOAD: assert property (@(posedge clk) disable iff (!rst_n)
                (wr_en && tgt == TGT_PRG0) |=> prg0_q == $past(wr_data[PRG_W-1:0])); // R2
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            prg0_q   <= '0;
            prg1_q   <= '0;
            mirror_q <= '0;
            swap_q   <= 1'b0;
            chr_q    <= '0;
        end else begin
            if (ld_prg0) prg0_q <= prg0_d;
            if (ld_prg1) prg1_q <= prg1_d;
            if (wr_en && tgt == TGT_MIRROR && wr_data != 8'hFF) mirror_q <= wr_data[1:0];
            if (wr_en && tgt == TGT_MODE) swap_q <= wr_data[1];
            if (wr_en && tgt == TGT_CHR) begin
                if (chr_hi) chr_q[chr_idx][CHR_W-1:NIB] <= wr_data[NIB-1:0];
                else        chr_q[chr_idx][NIB-1:0]     <= wr_data[NIB-1:0];
            end
        end
    end

    AST_MIRROR_FF_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == TGT_MIRROR && wr_data == 8'hFF) |=> $stable(mirror_q)); // R4

    AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en || tgt == TGT_NONE) |=> ($stable(prg0_q) && $stable(prg1_q) &&
            $stable(mirror_q) && $stable(swap_q) && $stable(chr_q))); // R12

    AST_CHR_KEEP_HI: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && tgt == TGT_CHR && !chr_hi) |=>
            chr_q[$past(chr_idx)][CHR_W-1:NIB] == $past(chr_q[chr_idx][CHR_W-1:NIB])); // R9

endmodule

// File: rtl/prg_window_map.sv
module prg_window_map
    import bank_map_pkg::*;
#(
    parameter int PRG_W     = 5,
    parameter bit OUTER_BIT = 1'b1
) (
    input  logic [2:0]       addr_top,
    input  logic [PRG_W-1:0] prg0_q,
    input  logic [PRG_W-1:0] prg1_q,
    input  logic             swap_q,
    output logic [PRG_W:0]   bank,
    output logic             rom_hit,
    output logic             ram_hit
);
    localparam logic [PRG_W-1:0] BANK_LAST = {PRG_W{1'b1}};
    localparam logic [PRG_W-1:0] BANK_PREV = BANK_LAST - 1'b1;

    prg_win_e         win;
    logic [PRG_W-1:0] sel;

    always_comb begin
        rom_hit = addr_top[2];
        ram_hit = (addr_top == 3'b011);
        win     = prg_win_e'(addr_top[1:0]);
        unique case (win)
            WIN_LO:  sel = swap_q ? BANK_PREV : prg0_q;
            WIN_MID: sel = prg1_q;
            WIN_HI:  sel = swap_q ? prg0_q : BANK_PREV;
            WIN_TOP: sel = BANK_LAST;
            default: sel = BANK_LAST;
        endcase
        bank = rom_hit ? {OUTER_BIT, sel} : '0;
    end

endmodule

// File: rtl/chr_window_map.sv
module chr_window_map #(
    parameter int CHR_W = 8,
    parameter int CHR_N = 8,
    localparam int CHR_IDX_W = $clog2(CHR_N)
) (
    input  logic [CHR_IDX_W-1:0]        slice,
    input  logic [CHR_N-1:0][CHR_W-1:0] chr_q,
    output logic [CHR_W-1:0]            bank
);
    always_comb bank = chr_q[slice];
endmodule

// File: rtl/bank_map_decoder.sv
module bank_map_decoder
    import bank_map_pkg::*;
#(
    parameter int PRG_W     = 5,
    parameter int CHR_W     = 8,
    parameter int CHR_N     = 8,
    parameter bit OUTER_BIT = 1'b1,
    parameter bit PAIR_MODE = 1'b0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cpu_wr,
    input  logic [15:0]      cpu_addr,
    input  logic [7:0]       cpu_wdata,
    input  logic [12:0]      chr_addr,
    output logic [PRG_W:0]   prg_bank,
    output logic             prg_hit,
    output logic             wram_hit,
    output logic [CHR_W-1:0] chr_bank,
    output logic [1:0]       mirror_mode
);
    localparam int CHR_IDX_W = $clog2(CHR_N);

    wr_tgt_e                     tgt;
    logic [CHR_IDX_W-1:0]        chr_idx;
    logic                        chr_hi;
    logic [PRG_W-1:0]            prg0_q, prg1_q;
    logic                        swap_q;
    logic [CHR_N-1:0][CHR_W-1:0] chr_q;

    bank_wr_decode #(.CHR_IDX_W(CHR_IDX_W)) u_decode (
        .addr_page (cpu_addr[15:12]),
        .addr_low  (cpu_addr[7:0]),
        .tgt       (tgt),
        .chr_idx   (chr_idx),
        .chr_hi    (chr_hi)
    );

    bank_regs #(
        .PRG_W(PRG_W), .CHR_W(CHR_W), .CHR_N(CHR_N), .PAIR_MODE(PAIR_MODE)
    ) u_regs (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cpu_wr),
        .tgt      (tgt),
        .chr_idx  (chr_idx),
        .chr_hi   (chr_hi),
        .wr_data  (cpu_wdata),
        .prg0_q   (prg0_q),
        .prg1_q   (prg1_q),
        .mirror_q (mirror_mode),
        .swap_q   (swap_q),
        .chr_q    (chr_q)
    );

    prg_window_map #(.PRG_W(PRG_W), .OUTER_BIT(OUTER_BIT)) u_prg_map (
        .addr_top (cpu_addr[15:13]),
        .prg0_q   (prg0_q),
        .prg1_q   (prg1_q),
        .swap_q   (swap_q),
        .bank     (prg_bank),
        .rom_hit  (prg_hit),
        .ram_hit  (wram_hit)
    );

    chr_window_map #(.CHR_W(CHR_W), .CHR_N(CHR_N)) u_chr_map (
        .slice (chr_addr[12:10]),
        .chr_q (chr_q),
        .bank  (chr_bank)
    );

    always_comb begin
        if (prg_hit && cpu_addr[14:13] == 2'b11)
            AST_TOP_FIXED: assert (prg_bank[PRG_W-1:0] == {PRG_W{1'b1}}); // R7
    end

endmodule

// File: tb/bank_map_decoder_bench.sv
module bank_map_decoder_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic [7:0]  cpu_wdata = '0;
    logic [12:0] chr_addr = '0;
    logic [5:0]  prg_bank, p_prg_bank;
    logic        prg_hit, wram_hit, p_prg_hit, p_wram_hit;
    logic [7:0]  chr_bank, p_chr_bank;
    logic [1:0]  mirror_mode, p_mirror_mode;
    int n_chk = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    bank_map_decoder u_bank_map_decoder (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .chr_addr(chr_addr), .prg_bank(prg_bank),
        .prg_hit(prg_hit), .wram_hit(wram_hit), .chr_bank(chr_bank),
        .mirror_mode(mirror_mode)
    );

    bank_map_decoder #(.PAIR_MODE(1'b1)) u_bank_map_decoder_pair (
        .clk(clk), .rst_n(rst_n), .cpu_wr(cpu_wr), .cpu_addr(cpu_addr),
        .cpu_wdata(cpu_wdata), .chr_addr(chr_addr), .prg_bank(p_prg_bank),
        .prg_hit(p_prg_hit), .wram_hit(p_wram_hit), .chr_bank(p_chr_bank),
        .mirror_mode(p_mirror_mode)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [15:0] a, input logic [7:0] d);
        @(negedge clk);
        cpu_wr = 1'b1; cpu_addr = a; cpu_wdata = d;
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic prg_at(input logic [15:0] a, input string tag, input int exp);
        cpu_addr = a; #1;
        check(tag, prg_bank, exp);
    endtask

    task automatic chr_at(input logic [12:0] a, input string tag, input int exp);
        chr_addr = a; #1;
        check(tag, chr_bank, exp);
    endtask

    task automatic t_reset;
        prg_at(16'h8000, "R12 reset 8000", 8'h20);
        prg_at(16'hA000, "R12 reset A000", 8'h20);
        prg_at(16'hC000, "R6 reset C000 fixed 1E", 8'h3E);
        prg_at(16'hE000, "R7 reset E000 fixed 1F", 8'h3F);
        check("R12 reset mirror", mirror_mode, 0);
        chr_at(13'h1C00, "R12 reset chr", 0);
    endtask

    task automatic t_prg;
        wr(16'h8000, 8'hE5);
        prg_at(16'h8000, "R2 prg0 low5", 8'h25);
        wr(16'h8003, 8'h0B);
        prg_at(16'h9FFF, "R2 prg0 alias 8003", 8'h2B);
        wr(16'hA002, 8'h1A);
        prg_at(16'hA000, "R3 prg1", 8'h3A);
        prg_at(16'hBFFF, "R3 prg1 window end", 8'h3A);
        prg_at(16'hFFFF, "R7 top fixed", 8'h3F);
    endtask

    task automatic t_mirror;
        wr(16'h9000, 8'h02);
        check("R5 single page A", mirror_mode, 2);
        wr(16'h9001, 8'hFF);
        check("R4 FF ignored", mirror_mode, 2);
        wr(16'h9001, 8'h03);
        check("R5 single page B", mirror_mode, 3);
        wr(16'h9000, 8'h01);
        check("R5 horizontal", mirror_mode, 1);
    endtask

    task automatic t_fold_swap;
        wr(16'h9008, 8'h02);               // folds to 0x9002: swap on
        prg_at(16'h8000, "R6 swapped 8000", 8'h3E);
        prg_at(16'hC000, "R6 swapped C000", 8'h2B);
        check("R1 fold kept mirror", mirror_mode, 1);
        wr(16'h9002, 8'h00);
        prg_at(16'h8000, "R6 unswapped 8000", 8'h2B);
        wr(16'h9010, 8'h00);               // folds to 0x9001
        check("R1 fold to mirror", mirror_mode, 0);
    endtask

    task automatic t_chr;
        wr(16'hC002, 8'h07);
        wr(16'hC003, 8'h05);
        chr_at(13'h0C00, "R8 chr reg3", 8'h57);
        chr_at(13'h0FFF, "R10 chr slice end", 8'h57);
        wr(16'hB040, 8'h09);               // folds to 0xB001
        chr_at(13'h0000, "R1 fold chr0 hi", 8'h90);
        wr(16'hE001, 8'h0A);
        wr(16'hE000, 8'hF3);
        chr_at(13'h1800, "R9 nibble keep", 8'hA3);
        chr_at(13'h1C00, "R10 chr7 untouched", 0);
        wr(16'hD002, 8'h04);
        chr_at(13'h1400, "R8 chr reg5", 8'h04);
    endtask

    task automatic t_ignore;
        wr(16'hF000, 8'h55);
        wr(16'h7000, 8'h66);
        wr(16'h4003, 8'h77);
        prg_at(16'h8000, "R12 ignored prg0", 8'h2B);
        prg_at(16'hA000, "R12 ignored prg1", 8'h3A);
        check("R12 ignored mirror", mirror_mode, 0);
        chr_at(13'h0C00, "R12 ignored chr", 8'h57);
    endtask

    task automatic t_wram;
        cpu_addr = 16'h6000; #1;
        check("R11 wram 6000", {wram_hit, prg_hit}, 2'b10);
        cpu_addr = 16'h7FFF; #1;
        check("R11 wram 7FFF", {wram_hit, prg_hit}, 2'b10);
        cpu_addr = 16'h5FFF; #1;
        check("R11 below wram", {wram_hit, prg_hit, prg_bank}, 0);
        cpu_addr = 16'h8000; #1;
        check("R11 rom 8000", {wram_hit, prg_hit}, 2'b01);
    endtask

    task automatic t_pair;
        // earlier A002<=1A left the pair at 14/15
        cpu_addr = 16'h8000; #1;
        check("R3 pair after A002", p_prg_bank, 8'h34);
        wr(16'h8000, 8'h11);
        cpu_addr = 16'h8000; #1;
        check("R3 pair 8000 ignored", p_prg_bank, 8'h34);
        wr(16'hA001, 8'h07);
        cpu_addr = 16'h8000; #1;
        check("R3 pair even", p_prg_bank, 8'h2E);
        cpu_addr = 16'hA000; #1;
        check("R3 pair odd", p_prg_bank, 8'h2F);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_prg();
        t_mirror();
        t_fold_swap();
        t_chr();
        t_ignore();
        t_wram();
        t_pair();
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=hung expected=done");
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

endmodule